// File: doc/BRIEF.md
# Receive Interrupt Moderation Timer

This block decides when a network receive path raises its receive-timer interrupt. Its aim is fewer interrupts per unit of work during packet bursts. It keeps two down-counters that advance only on a free-running time-base tick:

- The **packet delay timer** is reloaded and restarted by every packet whose data has fully landed in host memory. It fires once the link has been quiet for the programmed delay.
- The **absolute timer** starts on the first packet after an interrupt, or after a period with no timer running. Later packets do not restart it, so a long unbroken burst still gets serviced within a bounded time.

Several other events also raise the receive-timer interrupt:

- A programmed delay of zero turns both timers off, and every packet then interrupts.
- A write of the delay register with its flush bit set fires at once. It also asks the descriptor logic to write back consumed descriptors.
- A small-packet detection fires immediately. It leaves the packet timer reloaded but stopped.

Four receive cause bits are latched in a sticky register and cleared by a host read-clear pulse. A masked OR of the cause bits forms the level interrupt. No pin carries a data stream, so every port is a plain control or status signal and there is no back-pressure.

Top module: `rx_irq_moderator`

## Requirements
- R1: After reset, `rxt_pulse`, `flush_req`, `irq` are 0, `cause` is 4'b0000, the delay, absolute and mask registers are 0.
- R2: With a stored delay D>0 and no other event, a packet accepted at clock edge t gives exactly one `rxt_pulse`, visible after the edge at which D ticks have elapsed (edge t+D when `tick` is held high).
- R3: Every packet reloads and restarts the packet delay timer. A packet arriving on the very edge at which the timer expires still gives that pulse, and then restarts the timer for itself.
- R4: With a stored delay of 0, every packet gives an `rxt_pulse` after its own edge, and the absolute timer never runs.
- R5: The absolute timer loads from its register (`cfg_sel`=1, low bits) on a packet while it is not running, or while an interrupt is firing. Later packets leave it alone. Its expiry gives an `rxt_pulse` and stops it. A stored value of 0 disables it.
- R6: A delay write (`cfg_sel`=0) with `cfg_wdata[31]`=1 gives `rxt_pulse` and `flush_req` together after that edge, and stops both timers so the pending packet gives no later pulse. Bit 31 is not stored, and the low bits become the new delay.
- R7: A `small_pkt` pulse sets cause bit 3 and gives an `rxt_pulse`. The packet timer is reloaded but not started, so no further pulse occurs until another packet arrives.
- R8: The cause bits are bit 0 receive timer, bit 1 descriptor threshold (`thresh_evt`), bit 2 FIFO overrun (`overrun_evt`), and bit 3 small packet. They stay set until `cause_clr`. A bit being set in the same cycle as `cause_clr` stays set.
- R9: `irq` is high exactly when some cause bit is set whose mask bit is set. The mask is written with `cfg_sel`=2 from `cfg_wdata[3:0]`.
- R10: The timers advance only on cycles with `tick` high. With `tick` low, a running timer never expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_done | input | 1 | Packet fully written to host memory (one-cycle pulse) |
| small_pkt | input | 1 | Small-packet detection pulse |
| thresh_evt | input | 1 | Descriptor minimum threshold event pulse |
| overrun_evt | input | 1 | Receive FIFO overrun event pulse |
| tick | input | 1 | Time-base tick, one timer step per high cycle |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 delay, 1 absolute, 2 mask |
| cfg_wdata | input | 32 | Write data; bit 31 is the flush bit for delay writes |
| cause_clr | input | 1 | Host read-clear pulse for the cause register |
| rxt_pulse | output | 1 | Receive-timer interrupt pulse |
| flush_req | output | 1 | Descriptor write-back request pulse |
| cause | output | 4 | Sticky receive cause bits |
| irq | output | 1 | Masked OR of the cause bits |

## Verification
The bench builds the block with 8-bit delay and absolute timers. This keeps the flush bit at 31, so the unstored upper write bits are still exercised. With the tick held high, every delay from 1 to 6 is crossed with every gap from 1 to 8 between two packets. That sweep covers the cases where the second packet comes before, exactly on, and after the expiry edge, each with an expected pulse schedule worked out arithmetically. Further runs cover the absolute timer under a steady packet stream, gated ticks, flush writes, small-packet events, and cause and mask handling.

// File: rtl/rxm_pkg.sv
package rxm_pkg;
  localparam int CAUSE_N     = 4;
  localparam int CB_TIMER    = 0;
  localparam int CB_THRESH   = 1;
  localparam int CB_OVERRUN  = 2;
  localparam int CB_SMALL    = 3;

  typedef enum logic [1:0] {
    SEL_DELAY = 2'd0,
    SEL_ABS   = 2'd1,
    SEL_MASK  = 2'd2
  } cfg_sel_e;
endpackage

// File: rtl/rxm_cfg_regs.sv
module rxm_cfg_regs
  import rxm_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DLY_W     = 16,
  parameter int ABS_W     = 16,
  parameter int FLUSH_BIT = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DLY_W-1:0]  dly_q,
  output logic [ABS_W-1:0]  abs_q,
  output logic [CAUSE_N-1:0] mask_q,
  output logic              flush_hit
);
  cfg_sel_e sel;
  logic     unused_wdata;

  assign sel          = cfg_sel_e'(wr_sel);
  assign unused_wdata = ^wr_data;
  // Flush fires on the write itself; the bit is never held.
  assign flush_hit    = wr_en && (sel == SEL_DELAY) && wr_data[FLUSH_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dly_q  <= '0;
      abs_q  <= '0;
      mask_q <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_DELAY: dly_q  <= wr_data[DLY_W-1:0];
        SEL_ABS:   abs_q  <= wr_data[ABS_W-1:0];
        SEL_MASK:  mask_q <= wr_data[CAUSE_N-1:0];
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/rxm_countdown.sv
module rxm_countdown #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         start,     // reload and run (wins over halt)
  input  logic         halt,      // reload and stop
  input  logic [W-1:0] load_val,
  output logic         expire,
  output logic         running
);
  logic [W-1:0] cnt_q;
  logic         run_q;

  assign expire  = run_q && tick && (cnt_q == W'(1));
  assign running = run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      cnt_q <= load_val;
      run_q <= (load_val != '0);
    end else if (halt) begin
      cnt_q <= load_val;
      run_q <= 1'b0;
    end else if (expire) begin
      run_q <= 1'b0;
    end else if (run_q && tick) begin
      cnt_q <= cnt_q - W'(1);
    end
  end
endmodule

// File: rtl/rxm_cause_reg.sv
module rxm_cause_reg
  import rxm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CAUSE_N-1:0] set_vec,
  input  logic               clr,
  input  logic [CAUSE_N-1:0] mask,
  output logic [CAUSE_N-1:0] cause_q,
  output logic               irq
);
  for (genvar i = 0; i < CAUSE_N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)          cause_q[i] <= 1'b0;
      else if (set_vec[i]) cause_q[i] <= 1'b1;
      else if (clr)        cause_q[i] <= 1'b0;
    end
  end

  assign irq = |(cause_q & mask);
endmodule

// File: rtl/rx_irq_moderator.sv
module rx_irq_moderator
  import rxm_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DLY_W     = 16,
  parameter int ABS_W     = 16,
  parameter int FLUSH_BIT = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_done,
  input  logic              small_pkt,
  input  logic              thresh_evt,
  input  logic              overrun_evt,
  input  logic              tick,
  input  logic              cfg_wr_en,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              cause_clr,
  output logic              rxt_pulse,
  output logic              flush_req,
  output logic [CAUSE_N-1:0] cause,
  output logic              irq
);
  logic [DLY_W-1:0]   dly_q;
  logic [ABS_W-1:0]   abs_q;
  logic [CAUSE_N-1:0] mask_q;
  logic               flush_hit;
  logic               dly_zero;
  logic               pkt_exp, pkt_run;
  logic               abs_exp, abs_run;
  logic               pkt_start, pkt_halt;
  logic               abs_start, abs_halt;
  logic               fire;
  logic [CAUSE_N-1:0] set_vec;
  logic               rxt_q, flush_q;

  rxm_cfg_regs #(
    .DATA_W(DATA_W), .DLY_W(DLY_W), .ABS_W(ABS_W), .FLUSH_BIT(FLUSH_BIT)
  ) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_sel(cfg_sel),
    .wr_data(cfg_wdata), .dly_q(dly_q), .abs_q(abs_q), .mask_q(mask_q),
    .flush_hit(flush_hit)
  );

  assign dly_zero = (dly_q == '0);

  // Every interrupt-raising event of this cycle, expiry taken first.
  assign fire = flush_hit | pkt_exp | abs_exp | small_pkt | (pkt_done & dly_zero);

  // A new packet restarts the delay timer even on an expiry edge.
  assign pkt_start = pkt_done & ~dly_zero;
  assign pkt_halt  = flush_hit | abs_exp | small_pkt | dly_zero;

  // Absolute timer arms on the first packet of a new moderation window.
  assign abs_start = pkt_start & (~abs_run | fire);
  assign abs_halt  = fire | dly_zero;

  rxm_countdown #(.W(DLY_W)) pkt_tmr_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(pkt_start), .halt(pkt_halt),
    .load_val(dly_q), .expire(pkt_exp), .running(pkt_run)
  );

  rxm_countdown #(.W(ABS_W)) abs_tmr_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(abs_start), .halt(abs_halt),
    .load_val(abs_q), .expire(abs_exp), .running(abs_run)
  );

  always_comb begin
    set_vec              = '0;
    set_vec[CB_TIMER]    = fire;
    set_vec[CB_THRESH]   = thresh_evt;
    set_vec[CB_OVERRUN]  = overrun_evt;
    set_vec[CB_SMALL]    = small_pkt;
  end

  rxm_cause_reg cause_i (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr(cause_clr),
    .mask(mask_q), .cause_q(cause), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxt_q   <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      rxt_q   <= fire;
      flush_q <= flush_hit;
    end
  end

  assign rxt_pulse = rxt_q;
  assign flush_req = flush_q;

  logic unused_run;
  assign unused_run = pkt_run;
endmodule

// File: rtl/rxm_checker.sv
module rxm_checker
  import rxm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DLY_W  = 16,
  parameter int FLUSH_BIT = DATA_W - 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pkt_done,
  input logic               small_pkt,
  input logic               thresh_evt,
  input logic               overrun_evt,
  input logic               tick,
  input logic               cfg_wr_en,
  input logic [1:0]         cfg_sel,
  input logic [DATA_W-1:0]  cfg_wdata,
  input logic               cause_clr,
  input logic               rxt_pulse,
  input logic               flush_req,
  input logic [CAUSE_N-1:0] cause,
  input logic               irq,
  input logic [DLY_W-1:0]   dly_q
);
  p_timer_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rxt_pulse |-> cause[CB_TIMER]);

  p_zero_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && dly_q == '0) |=> rxt_pulse);

  p_flush_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> rxt_pulse);

  p_flush_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> $past(cfg_wr_en && cfg_sel == 2'd0 && cfg_wdata[FLUSH_BIT]));

  p_small_r7: assert property (@(posedge clk) disable iff (!rst_n)
    small_pkt |=> (rxt_pulse && cause[CB_SMALL]));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_clr |=> ((cause & $past(cause)) == $past(cause)));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_clr && !tick && !pkt_done && !small_pkt && !thresh_evt &&
     !overrun_evt && !cfg_wr_en) |=> (cause == '0));

  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cause != '0));

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !pkt_done && !small_pkt && !cfg_wr_en) |=> !rxt_pulse);
endmodule

bind rx_irq_moderator rxm_checker #(
  .DATA_W(DATA_W), .DLY_W(DLY_W), .FLUSH_BIT(FLUSH_BIT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .pkt_done(pkt_done), .small_pkt(small_pkt),
  .thresh_evt(thresh_evt), .overrun_evt(overrun_evt), .tick(tick),
  .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
  .cause_clr(cause_clr), .rxt_pulse(rxt_pulse), .flush_req(flush_req),
  .cause(cause), .irq(irq), .dly_q(dly_q)
);

// File: tb/rx_irq_moderator_tb.sv
module rx_irq_moderator_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pkt_done = 1'b0, small_pkt = 1'b0, thresh_evt = 1'b0, overrun_evt = 1'b0;
  logic        tick = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        cause_clr = 1'b0;
  logic        rxt_pulse, flush_req, irq;
  logic [3:0]  cause;

  int total = 0, bad = 0, cyc = 0;
  int rec[8];
  int frec[4];
  int n_rec = 0, n_frec = 0;
  bit done = 0;

  rx_irq_moderator #(.DATA_W(32), .DLY_W(8), .ABS_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .pkt_done(pkt_done), .small_pkt(small_pkt),
    .thresh_evt(thresh_evt), .overrun_evt(overrun_evt), .tick(tick),
    .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cause_clr(cause_clr), .rxt_pulse(rxt_pulse), .flush_req(flush_req),
    .cause(cause), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rxt_pulse && n_rec < 8) begin rec[n_rec] = cyc; n_rec++; end
    if (flush_req && n_frec < 4) begin frec[n_frec] = cyc; n_frec++; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_wdata = '0;
  endtask

  task automatic clr_all();
    @(negedge clk); cause_clr = 1'b1;
    @(negedge clk); cause_clr = 1'b0;
    n_rec = 0; n_frec = 0;
  endtask

  // Compare recorded pulse edges, relative to base, with the expected list.
  task automatic expect_pulses(input string req, input int base, input int n,
                               input int e0, input int e1, input int e2, input int e3);
    int ex[4];
    ex[0] = e0; ex[1] = e1; ex[2] = e2; ex[3] = e3;
    chk(n_rec == n, req, n_rec, n);
    for (int i = 0; i < n && i < n_rec; i++)
      chk(rec[i] - base == ex[i], req, rec[i] - base, ex[i]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int t0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk(rxt_pulse == 0, "R1 rxt_pulse", rxt_pulse, 0);
    chk(flush_req == 0, "R1 flush_req", flush_req, 0);
    chk(cause == 0, "R1 cause", cause, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    // R1 delay register is 0 after reset: a packet interrupts at once
    n_rec = 0;
    @(negedge clk); pkt_done = 1; t0 = cyc + 1;
    @(negedge clk); pkt_done = 0;
    idle(6);
    expect_pulses("R1 zero delay after reset", t0, 1, 0, 0, 0, 0);
    clr_all();

    // R4 zero delay: packets at offsets 0,1,3
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      pkt_done = (k == 0) || (k == 1) || (k == 3);
      if (k == 0) t0 = cyc + 1;
    end
    pkt_done = 0;
    expect_pulses("R4 per-packet", t0, 3, 0, 1, 3, 0);
    clr_all();

    // R2/R3 sweep over delay and gap
    for (int d = 1; d <= 6; d++) begin
      for (int g = 1; g <= 8; g++) begin
        wr(2'd0, 32'(d));
        idle(2);
        n_rec = 0;
        for (int k = 0; k <= g + d + 8; k++) begin
          @(negedge clk);
          pkt_done = (k == 0) || (k == g);
          if (k == 0) t0 = cyc + 1;
        end
        pkt_done = 0;
        if (g < d)       expect_pulses("R3 restart", t0, 1, g + d, 0, 0, 0);
        else if (g == d) expect_pulses("R3 same-edge", t0, 2, d, 2 * d, 0, 0);
        else             expect_pulses("R2 two expiries", t0, 2, d, g + d, 0, 0);
        clr_all();
      end
    end

    // R7 small packet: D=5, packet at 0, small at 2
    wr(2'd0, 32'd5);
    idle(2); n_rec = 0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      pkt_done  = (k == 0);
      small_pkt = (k == 2);
      if (k == 0) t0 = cyc + 1;
    end
    small_pkt = 0; pkt_done = 0;
    expect_pulses("R7 small stops timer", t0, 1, 2, 0, 0, 0);
    chk(cause == 4'b1001, "R7 cause bits", cause, 4'b1001);
    clr_all();
    @(negedge clk); pkt_done = 1; t0 = cyc + 1;
    @(negedge clk); pkt_done = 0;
    idle(10);
    expect_pulses("R7 next packet restarts", t0, 1, 5, 0, 0, 0);
    clr_all();

    // R6 flush: D=5, packet at 0, flush write with delay 3 at 2
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      pkt_done  = (k == 0);
      cfg_wr_en = (k == 2);
      cfg_sel   = 2'd0;
      cfg_wdata = (k == 2) ? 32'h8000_0003 : 32'h0;
      if (k == 0) t0 = cyc + 1;
    end
    cfg_wr_en = 0; pkt_done = 0;
    expect_pulses("R6 flush fires", t0, 1, 2, 0, 0, 0);
    chk(n_frec == 1, "R6 flush_req count", n_frec, 1);
    if (n_frec > 0) chk(frec[0] - t0 == 2, "R6 flush_req edge", frec[0] - t0, 2);
    clr_all();
    @(negedge clk); pkt_done = 1; t0 = cyc + 1;
    @(negedge clk); pkt_done = 0;
    idle(10);
    expect_pulses("R6 low bits stored", t0, 1, 3, 0, 0, 0);
    chk(n_frec == 0, "R6 flush bit not stored", n_frec, 0);
    clr_all();

    // R10 tick gating: D=2, tick low for 15 cycles
    wr(2'd0, 32'd2);
    @(negedge clk); tick = 0; pkt_done = 1;
    @(negedge clk); pkt_done = 0;
    idle(15);
    chk(n_rec == 0, "R10 no tick no expiry", n_rec, 0);
    @(negedge clk); tick = 1; t0 = cyc + 1;
    idle(6);
    expect_pulses("R10 resumes on tick", t0, 1, 1, 0, 0, 0);
    clr_all();

    // R5 absolute timer: D=4, A=6, packets every 2 cycles for 10 packets
    wr(2'd1, 32'd6);
    wr(2'd0, 32'd4);
    idle(2); n_rec = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      pkt_done = (k <= 18) && (k % 2 == 0);
      if (k == 0) t0 = cyc + 1;
    end
    pkt_done = 0;
    chk(n_rec == 4, "R5 count", n_rec, 4);
    for (int i = 0; i < 4 && i < n_rec; i++)
      chk(rec[i] - t0 == ((i < 3) ? 6 * (i + 1) : 22), "R5 edge", rec[i] - t0,
          (i < 3) ? 6 * (i + 1) : 22);
    wr(2'd1, 32'd0);
    clr_all();

    // R8/R9 cause bits and mask
    @(negedge clk); thresh_evt = 1; overrun_evt = 1;
    @(negedge clk); thresh_evt = 0; overrun_evt = 0;
    chk(cause == 4'b0110, "R8 thresh/overrun bits", cause, 4'b0110);
    chk(irq == 0, "R9 mask zero", irq, 0);
    wr(2'd2, 32'h4);
    chk(irq == 1, "R9 overrun unmasked", irq, 1);
    wr(2'd2, 32'h1);
    chk(irq == 0, "R9 timer only mask", irq, 0);
    idle(4);
    chk(cause == 4'b0110, "R8 sticky", cause, 4'b0110);
    @(negedge clk); cause_clr = 1; thresh_evt = 1;
    @(negedge clk); cause_clr = 0; thresh_evt = 0;
    chk(cause == 4'b0010, "R8 set wins over clear", cause, 4'b0010);
    clr_all();
    chk(cause == 0, "R8 cleared", cause, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule